// File: doc/BRIEF.md
# Accumulator AND Execute Unit

This unit carries out the accumulator forms of a bitwise AND instruction. A decoder hands it one operation at a time: a destination accumulator index, a selector for where the source comes from, and a flag for two- or three-operand use. The source is either a memory word that has already been fetched (16 data bits plus one extra tag bit), a 16-bit immediate, or a second accumulator. Complement selectors can invert the accumulator operands. A "neighbour" bit can send the result to the other accumulator of the addressed even/odd pair.

Each accepted operation writes the target accumulator. It refreshes the sign, zero, carry and overflow flags and, for memory data, the tag flag. It reports the word and cycle cost of the instruction and advances a program counter by the word count. Accumulator-to-accumulator operations can be repeated a given number of times. During the repeat the unit holds off new operations until the repeat overhead has elapsed. A load port lets the surrounding pipeline seed accumulators while the unit is idle.

Top module: `acc_and_unit`

## Requirements
- R1: After reset all accumulators, the program counter, every flag and `res_valid` are zero, and `op_ready` is 1.
- R2: Two-operand mode (`op_three`=0) writes target = target AND operand. The operand is the memory word for `op_src_sel`=0, the immediate for 1, and accumulator `op_src` for 2 or 3. For the accumulator source it is inverted when `op_inv_a`=1. In this mode `op_inv_b` has no effect.
- R3: Three-operand mode (`op_three`=1) writes target = S AND Y. S is accumulator `op_src`, inverted when `op_inv_a`=1. Y is the immediate for `op_src_sel`=1, or the target accumulator (inverted when `op_inv_b`=1) for the accumulator source. With memory source (`op_src_sel`=0), `op_three` and both invert bits are ignored.
- R4: The target index is `op_dest` with bit 0 flipped when `op_next`=1, and `op_dest` otherwise.
- R5: Each write sets the sign flag to result bit 15 and sets the zero flag when the result is 0. It clears the carry and overflow flags.
- R6: A memory-sourced operation loads `flag_tag` from `op_mem_tag`. Other forms leave `flag_tag` unchanged.
- R7: An accepted operation reports 2 words and 2 cycles for the immediate form, and 1 word and 1 cycle for the memory and accumulator forms. `pc` advances by the word count.
- R8: For the accumulator source with `op_rpt`=1, the operation is applied N times, where N is `op_rpt_cnt` (0 counts as 1). `op_ready` stays low for N+2 cycles after acceptance, and the reported cycle count is N+3.
- R9: For the immediate and memory sources, `op_rpt` is ignored: one application, no busy time, the usual cycle count.
- R10: An `op_valid` presented while `op_ready` is low is ignored. Accumulators, flags and `pc` are untouched by it.
- R11: `ld_en` writes `ld_data` into accumulator `ld_idx` only in a cycle where no operation is accepted and the unit is not busy. Otherwise it is ignored.
- R12: In the cycle after every accumulator write by an operation, `res_valid` is 1, with `res_acc` and `res_data` giving the target and the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit can accept an operation |
| op_src_sel | input | 2 | 0 memory, 1 immediate, 2/3 accumulator |
| op_three | input | 1 | Three-operand mode |
| op_next | input | 1 | Target the other accumulator of the pair |
| op_inv_a | input | 1 | Invert the source accumulator |
| op_inv_b | input | 1 | Invert the target accumulator as operand (three-operand) |
| op_dest | input | 2 | Addressed accumulator |
| op_src | input | 2 | Source accumulator |
| op_mem_data | input | 16 | Fetched memory data |
| op_mem_tag | input | 1 | Extra bit of the fetched memory word |
| op_imm | input | 16 | Immediate operand |
| op_rpt | input | 1 | Repeat requested |
| op_rpt_cnt | input | 8 | Repeat count |
| ld_en | input | 1 | Accumulator load strobe |
| ld_idx | input | 2 | Accumulator to load |
| ld_data | input | 16 | Load value |
| obs_idx | input | 2 | Accumulator to observe |
| obs_data | output | 16 | Observed accumulator contents |
| res_valid | output | 1 | A write happened last cycle |
| res_acc | output | 2 | Index written |
| res_data | output | 16 | Value written |
| flag_of | output | 1 | Overflow flag |
| flag_sf | output | 1 | Sign flag |
| flag_zf | output | 1 | Zero flag |
| flag_cf | output | 1 | Carry flag |
| flag_tag | output | 1 | Tag flag |
| instr_words | output | 2 | Words used by the last accepted operation |
| instr_cycles | output | 10 | Cycles used by the last accepted operation |
| pc | output | 16 | Program counter |

## Verification
A single-shot operation lands one clock after the accepting edge. At that point the target accumulator, the flags, `res_*`, `instr_words`, `instr_cycles` and `pc` are all final, so the bench reads them at the next falling edge. A repeated operation keeps writing for N-1 further edges and releases `op_ready` after N+2 busy cycles. The bench counts the falling edges at which `op_ready` is low, compares that count plus one with N+3, and only then reads the accumulators back through the observe port. For the ignore cases (a second operation or a load during busy, a load in an accepting cycle), the bench waits until the unit is idle and reads back every accumulator and `pc`.

// File: rtl/acc_and_pkg.sv
`timescale 1ns/1ps
package acc_and_pkg;
  localparam int ACC_DW = 16;

  typedef logic [ACC_DW-1:0] word_t;

  typedef enum logic [1:0] {
    SRC_MEM     = 2'd0,
    SRC_IMM     = 2'd1,
    SRC_ACC     = 2'd2,
    SRC_ACC_ALT = 2'd3
  } src_e;

  function automatic logic is_acc_src(src_e f);
    return (f == SRC_ACC) || (f == SRC_ACC_ALT);
  endfunction

  function automatic logic [1:0] words_of(src_e f);
    return (f == SRC_IMM) ? 2'd2 : 2'd1;
  endfunction

  // AND of the two selected operands; memory source is always two-operand.
  function automatic word_t and_exec(src_e f, logic three, logic inva, logic invb,
                                     word_t at, word_t as, word_t mem, word_t imm);
    word_t lhs;
    word_t rhs;
    word_t as_m;
    logic  use3;
    use3 = three && (f != SRC_MEM);
    as_m = as ^ {ACC_DW{inva}};
    lhs  = use3 ? as_m : at;
    case (f)
      SRC_MEM: rhs = mem;
      SRC_IMM: rhs = imm;
      default: rhs = use3 ? (at ^ {ACC_DW{invb}}) : as_m;
    endcase
    return lhs & rhs;
  endfunction
endpackage

// File: rtl/acc_and_regfile.sv
`timescale 1ns/1ps
module acc_and_regfile #(
  parameter int NUM_ACC = 4,
  parameter int DW      = 16,
  parameter int NRD     = 3,
  localparam int IW     = $clog2(NUM_ACC)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [IW-1:0]            widx,
  input  logic [DW-1:0]            wdata,
  input  logic [NRD-1:0][IW-1:0]   rd_idx,
  output logic [NRD-1:0][DW-1:0]   rd_data
);
  logic [DW-1:0] acc_q [NUM_ACC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ACC; i++) acc_q[i] <= '0;
    end else if (we) begin
      acc_q[widx] <= wdata;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g] = acc_q[rd_idx[g]];
  end
endmodule

// File: rtl/acc_and_alu.sv
`timescale 1ns/1ps
module acc_and_alu
  import acc_and_pkg::*;
(
  input  src_e  form,
  input  logic  three,
  input  logic  inv_a,
  input  logic  inv_b,
  input  word_t acc_tgt,
  input  word_t acc_src,
  input  word_t mem_data,
  input  word_t imm,
  output word_t result,
  output logic  sign,
  output logic  zero
);
  always_comb begin
    result = and_exec(form, three, inv_a, inv_b, acc_tgt, acc_src, mem_data, imm);
    sign   = result[ACC_DW-1];
    zero   = (result == '0);
  end
endmodule

// File: rtl/acc_and_seq.sv
`timescale 1ns/1ps
module acc_and_seq #(
  parameter int CNT_W = 8,
  localparam int BW   = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_rpt,
  input  logic [CNT_W-1:0] start_n,
  output logic             busy,
  output logic             iter_go
);
  logic [BW-1:0]    busy_cnt;
  logic [CNT_W-1:0] iter_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt  <= '0;
      iter_left <= '0;
    end else if (start) begin
      busy_cnt  <= start_rpt ? BW'(start_n) + BW'(2) : '0;
      iter_left <= start_rpt ? start_n - CNT_W'(1) : '0;
    end else if (busy_cnt != '0) begin
      busy_cnt <= busy_cnt - BW'(1);
      if (iter_left != '0) iter_left <= iter_left - CNT_W'(1);
    end
  end

  assign busy    = (busy_cnt != '0);
  assign iter_go = (iter_left != '0);

  // R8: pending iterations only while the unit is holding off new work
  assert_iter_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    iter_go |-> busy);
  // R8: busy time begins only from an accepted operation
  assert_busy_from_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

// File: rtl/acc_and_unit.sv
`timescale 1ns/1ps
module acc_and_unit
  import acc_and_pkg::*;
#(
  parameter int NUM_ACC = 4,
  parameter int CNT_W   = 8,
  parameter int PC_W    = 16,
  localparam int IW     = $clog2(NUM_ACC),
  localparam int CYC_W  = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [1:0]       op_src_sel,
  input  logic             op_three,
  input  logic             op_next,
  input  logic             op_inv_a,
  input  logic             op_inv_b,
  input  logic [IW-1:0]    op_dest,
  input  logic [IW-1:0]    op_src,
  input  logic [ACC_DW-1:0] op_mem_data,
  input  logic             op_mem_tag,
  input  logic [ACC_DW-1:0] op_imm,
  input  logic             op_rpt,
  input  logic [CNT_W-1:0] op_rpt_cnt,
  input  logic             ld_en,
  input  logic [IW-1:0]    ld_idx,
  input  logic [ACC_DW-1:0] ld_data,
  input  logic [IW-1:0]    obs_idx,
  output logic [ACC_DW-1:0] obs_data,
  output logic             res_valid,
  output logic [IW-1:0]    res_acc,
  output logic [ACC_DW-1:0] res_data,
  output logic             flag_of,
  output logic             flag_sf,
  output logic             flag_zf,
  output logic             flag_cf,
  output logic             flag_tag,
  output logic [1:0]       instr_words,
  output logic [CYC_W-1:0] instr_cycles,
  output logic [PC_W-1:0]  pc
);
  // ---------------- named internal events
  logic busy, iter_go, accept, exec, rf_we;
  src_e in_form, cur_form;
  logic [IW-1:0] in_tgt, cur_tgt, cur_src, rf_widx;
  logic cur_three, cur_inv_a, cur_inv_b;
  logic is_rpt;
  logic [CNT_W-1:0] n_eff;
  word_t alu_res, rf_wdata;
  logic  alu_sign, alu_zero;
  logic [2:0][IW-1:0]     rd_idx;
  logic [2:0][ACC_DW-1:0] rd_data;

  // latched operation for repeat iterations
  src_e          l_form;
  logic          l_three, l_inv_a, l_inv_b;
  logic [IW-1:0] l_tgt, l_src;

  assign in_form  = src_e'(op_src_sel);
  assign in_tgt   = op_next ? (op_dest ^ IW'(1)) : op_dest;
  assign op_ready = !busy;
  assign accept   = op_valid && !busy;
  assign exec     = accept || iter_go;
  assign is_rpt   = op_rpt && is_acc_src(in_form);
  assign n_eff    = (op_rpt_cnt == '0) ? CNT_W'(1) : op_rpt_cnt;

  assign cur_form  = busy ? l_form  : in_form;
  assign cur_three = busy ? l_three : op_three;
  assign cur_inv_a = busy ? l_inv_a : op_inv_a;
  assign cur_inv_b = busy ? l_inv_b : op_inv_b;
  assign cur_tgt   = busy ? l_tgt   : in_tgt;
  assign cur_src   = busy ? l_src   : op_src;

  assign rd_idx[0] = cur_tgt;
  assign rd_idx[1] = cur_src;
  assign rd_idx[2] = obs_idx;
  assign obs_data  = rd_data[2];

  assign rf_we    = exec || (ld_en && !busy && !accept);
  assign rf_widx  = exec ? cur_tgt : ld_idx;
  assign rf_wdata = exec ? alu_res : ld_data;

  acc_and_regfile #(.NUM_ACC(NUM_ACC), .DW(ACC_DW), .NRD(3)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .widx(rf_widx), .wdata(rf_wdata),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  acc_and_alu u_alu (
    .form(cur_form), .three(cur_three), .inv_a(cur_inv_a), .inv_b(cur_inv_b),
    .acc_tgt(rd_data[0]), .acc_src(rd_data[1]), .mem_data(op_mem_data),
    .imm(op_imm), .result(alu_res), .sign(alu_sign), .zero(alu_zero)
  );

  acc_and_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .start_rpt(is_rpt),
    .start_n(n_eff), .busy(busy), .iter_go(iter_go)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_form  <= SRC_MEM;
      l_three <= 1'b0;
      l_inv_a <= 1'b0;
      l_inv_b <= 1'b0;
      l_tgt   <= '0;
      l_src   <= '0;
    end else if (accept) begin
      l_form  <= in_form;
      l_three <= op_three;
      l_inv_a <= op_inv_a;
      l_inv_b <= op_inv_b;
      l_tgt   <= in_tgt;
      l_src   <= op_src;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_acc   <= '0;
      res_data  <= '0;
      flag_of   <= 1'b0;
      flag_sf   <= 1'b0;
      flag_zf   <= 1'b0;
      flag_cf   <= 1'b0;
    end else begin
      res_valid <= exec;
      if (exec) begin
        res_acc  <= cur_tgt;
        res_data <= alu_res;
        flag_of  <= 1'b0;
        flag_cf  <= 1'b0;
        flag_sf  <= alu_sign;
        flag_zf  <= alu_zero;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_tag     <= 1'b0;
      instr_words  <= '0;
      instr_cycles <= '0;
      pc           <= '0;
    end else if (accept) begin
      if (in_form == SRC_MEM) flag_tag <= op_mem_tag;
      instr_words  <= words_of(in_form);
      instr_cycles <= is_rpt ? CYC_W'(n_eff) + CYC_W'(3) : CYC_W'(words_of(in_form));
      pc           <= pc + PC_W'(words_of(in_form));
    end
  end

  // R5: flags agree with the value reported as written
  assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (flag_zf == (res_data == '0)) && (flag_sf == res_data[ACC_DW-1]));
  // R7: immediate form advances the program counter by two words
  assert_imm_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_src_sel == 2'd1) |=> (pc == $past(pc) + PC_W'(2)));
  // R9: immediate and memory forms never hold the unit busy
  assert_single_no_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !op_src_sel[1]) |=> !busy);
  // R10: while busy the program counter does not move
  assert_busy_pc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(pc));
  // R12: a reported write follows an operation write
  assert_res_after_exec_R12: assert property (@(posedge clk) disable iff (!rst_n)
    exec |=> res_valid);
endmodule

// File: tb/tb_acc_and_unit.sv
`timescale 1ns/1ps
module tb_acc_and_unit;
  typedef struct packed {
    logic [1:0]  sel;
    logic        three;
    logic        nxt;
    logic        ia;
    logic        ib;
    logic [1:0]  dst;
    logic [1:0]  src;
    logic [15:0] opnd;
    logic        tag;
    logic        rpt;
    logic [7:0]  cnt;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 16'h0FF0, 1'b1, 1'b0, 8'd0},
    '{2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 2'd0, 16'hF00F, 1'b0, 1'b0, 8'd0},
    '{2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd2, 2'd3, 16'hFFFF, 1'b0, 1'b0, 8'd0},
    '{2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 2'd2, 16'h0000, 1'b0, 1'b0, 8'd0},
    '{2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 2'd1, 16'h0000, 1'b0, 1'b0, 8'd0},
    '{2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 2'd2, 2'd0, 16'h0000, 1'b0, 1'b0, 8'd0},
    '{2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 2'd2, 16'h8001, 1'b0, 1'b0, 8'd0},
    '{2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 2'd1, 16'h00FF, 1'b0, 1'b1, 8'd5},
    '{2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 2'd1, 16'h0000, 1'b0, 1'b1, 8'd3},
    '{2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 2'd1, 16'h0000, 1'b0, 1'b1, 8'd0},
    '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 2'd0, 16'h0000, 1'b1, 1'b0, 8'd0},
    '{2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 16'h8000, 1'b0, 1'b1, 8'd0}
  };
  localparam logic [15:0] SEED [4] = '{16'hF0F3, 16'h3C3C, 16'hFF81, 16'h8FF0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        op_valid = 0, op_three = 0, op_next = 0, op_inv_a = 0, op_inv_b = 0;
  logic [1:0]  op_src_sel = 0, op_dest = 0, op_src = 0;
  logic [15:0] op_mem_data = 0, op_imm = 0;
  logic        op_mem_tag = 0, op_rpt = 0;
  logic [7:0]  op_rpt_cnt = 0;
  logic        ld_en = 0;
  logic [1:0]  ld_idx = 0, obs_idx = 0;
  logic [15:0] ld_data = 0;
  logic        op_ready, res_valid, flag_of, flag_sf, flag_zf, flag_cf, flag_tag;
  logic [1:0]  res_acc, instr_words;
  logic [15:0] obs_data, res_data, pc;
  logic [9:0]  instr_cycles;

  acc_and_unit dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_src_sel(op_src_sel), .op_three(op_three), .op_next(op_next),
    .op_inv_a(op_inv_a), .op_inv_b(op_inv_b), .op_dest(op_dest), .op_src(op_src),
    .op_mem_data(op_mem_data), .op_mem_tag(op_mem_tag), .op_imm(op_imm),
    .op_rpt(op_rpt), .op_rpt_cnt(op_rpt_cnt), .ld_en(ld_en), .ld_idx(ld_idx),
    .ld_data(ld_data), .obs_idx(obs_idx), .obs_data(obs_data),
    .res_valid(res_valid), .res_acc(res_acc), .res_data(res_data),
    .flag_of(flag_of), .flag_sf(flag_sf), .flag_zf(flag_zf), .flag_cf(flag_cf),
    .flag_tag(flag_tag), .instr_words(instr_words), .instr_cycles(instr_cycles), .pc(pc)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] m_acc [4];
  logic [15:0] m_pc = 0;
  logic        m_tag = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_and(vec_t v, logic [15:0] tv, logic [15:0] sv);
    logic [15:0] s_eff;
    s_eff = v.ia ? ~sv : sv;
    if (v.sel == 2'd0) return tv & v.opnd;
    if (!v.three) return (v.sel == 2'd1) ? (tv & v.opnd) : (tv & s_eff);
    if (v.sel == 2'd1) return s_eff & v.opnd;
    return s_eff & (v.ib ? ~tv : tv);
  endfunction

  task automatic load_seeds();
    for (int i = 0; i < 4; i++) begin
      ld_en = 1; ld_idx = 2'(i); ld_data = SEED[i];
      @(negedge clk);
      m_acc[i] = SEED[i];
    end
    ld_en = 0;
  endtask

  task automatic check_accs(string req);
    for (int i = 0; i < 4; i++) begin
      obs_idx = 2'(i);
      #0.5;
      chk(req, $sformatf("acc%0d", i), 32'(obs_data), 32'(m_acc[i]));
      @(negedge clk);
    end
  endtask

  task automatic drive(vec_t v);
    op_src_sel = v.sel; op_three = v.three; op_next = v.nxt; op_inv_a = v.ia;
    op_inv_b = v.ib; op_dest = v.dst; op_src = v.src; op_mem_data = v.opnd;
    op_imm = v.opnd; op_mem_tag = v.tag; op_rpt = v.rpt; op_rpt_cnt = v.cnt;
  endtask

  task automatic run_vec(vec_t v);
    logic [1:0]  t;
    logic [15:0] e;
    int iters, occ, ecyc;
    logic is_r, rv;
    logic [1:0] racc;
    logic [15:0] rdat;
    string rq;
    t = v.nxt ? (v.dst ^ 2'd1) : v.dst;
    is_r = v.sel[1] && v.rpt;
    iters = is_r ? ((v.cnt == 0) ? 1 : int'(v.cnt)) : 1;
    for (int k = 0; k < iters; k++) m_acc[t] = ref_and(v, m_acc[t], m_acc[v.src]);
    e = m_acc[t];
    ecyc = is_r ? iters + 3 : ((v.sel == 2'd1) ? 2 : 1);
    m_pc = m_pc + ((v.sel == 2'd1) ? 16'd2 : 16'd1);
    if (v.sel == 2'd0) m_tag = v.tag;
    rq = v.nxt ? "R4" : ((v.three && v.sel != 2'd0) ? "R3" : "R2");

    drive(v);
    op_valid = 1;
    @(posedge clk);
    @(negedge clk);
    op_valid = 0;
    rv = res_valid; racc = res_acc; rdat = res_data;
    occ = 1;
    while (!op_ready) begin
      @(negedge clk);
      occ++;
    end
    chk(is_r ? "R8" : "R9", "occupancy", 32'(occ), 32'(is_r ? iters + 3 : 1));
    if (!is_r) begin
      chk("R12", "res_valid", 32'(rv), 32'd1);
      chk("R12", "res_acc", 32'(racc), 32'(t));
      chk("R12", "res_data", 32'(rdat), 32'(e));
    end
    chk("R5", "flags{of,sf,zf,cf}", {28'd0, flag_of, flag_sf, flag_zf, flag_cf},
        {28'd0, 1'b0, e[15], (e == 16'd0), 1'b0});
    chk("R6", "tag", 32'(flag_tag), 32'(m_tag));
    chk("R7", "words", 32'(instr_words), 32'((v.sel == 2'd1) ? 2 : 1));
    chk(is_r ? "R8" : "R7", "cycles", 32'(instr_cycles), 32'(ecyc));
    chk("R7", "pc", 32'(pc), 32'(m_pc));
    obs_idx = t;
    #0.5;
    chk(rq, "target", 32'(obs_data), 32'(e));
    check_accs(rq);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog: actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    vec_t w;
    for (int i = 0; i < 4; i++) m_acc[i] = 16'd0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "op_ready", 32'(op_ready), 32'd1);
    chk("R1", "res_valid", 32'(res_valid), 32'd0);
    chk("R1", "pc", 32'(pc), 32'd0);
    chk("R1", "flags", {27'd0, flag_of, flag_sf, flag_zf, flag_cf, flag_tag}, 32'd0);
    check_accs("R1");
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      load_seeds();
      run_vec(VECS[i]);
    end

    // R10 / R11: operation and load presented while busy are ignored
    load_seeds();
    w = '{2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 2'd1, 16'h0000, 1'b0, 1'b1, 8'd4};
    for (int k = 0; k < 4; k++) m_acc[0] = ref_and(w, m_acc[0], m_acc[1]);
    m_pc = m_pc + 16'd1;
    drive(w);
    op_valid = 1;
    @(posedge clk);
    @(negedge clk);
    drive('{2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 16'h0000, 1'b0, 1'b0, 8'd0});
    ld_en = 1; ld_idx = 2'd2; ld_data = 16'h0000;
    repeat (2) @(negedge clk);
    op_valid = 0; ld_en = 0;
    while (!op_ready) @(negedge clk);
    chk("R10", "pc after busy", 32'(pc), 32'(m_pc));
    chk("R10", "flag_zf after busy", 32'(flag_zf), 32'(m_acc[0] == 16'd0));
    check_accs("R10");
    check_accs("R11");

    // R11: load in an accepting cycle is ignored
    load_seeds();
    w = '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 16'h00FF, 1'b0, 1'b0, 8'd0};
    m_acc[0] = m_acc[0] & 16'h00FF;
    m_pc = m_pc + 16'd1;
    m_tag = 1'b0;
    drive(w);
    op_valid = 1; ld_en = 1; ld_idx = 2'd3; ld_data = 16'h1234;
    @(posedge clk);
    @(negedge clk);
    op_valid = 0; ld_en = 0;
    chk("R11", "pc", 32'(pc), 32'(m_pc));
    chk("R6", "tag cleared", 32'(flag_tag), 32'(m_tag));
    check_accs("R11");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule